// File: doc/BRIEF.md
# SPI Serial EEPROM Slave Controller

This block lets a chip answer an SPI master as if it were a small serial EEPROM. The chip-select, serial clock, serial data in and hold lines come in as ordinary asynchronous inputs. They are resynchronised to a fast system clock, and a rising serial-clock edge is recognised in that clock domain. The block drives one serial data output.

Every transaction begins with an 8-bit instruction. Array commands then take a 16-bit address, and the address bits above the array size are discarded. The block holds a small status register made of a write-enable latch and two block-protect bits. It serves status reads and writes, latch set and clear, streaming byte reads that run across the whole array, and streaming writes that stay inside one page. A protect code shields the top quarter, the top half or all of the array from writes. The byte array sits behind a synchronous single-port memory with one cycle of read latency. Its depth and page size are parameters.

Top module: `spi_eeprom_slave`

## Requirements
- R1: Chip-select high (while hold is high) ends any operation. The output goes to 1, partial opcode/address/data bits are discarded, and the next low phase starts with a fresh opcode.
- R2: While hold is low, serial clock edges and chip-select changes have no effect. A command interrupted by a hold continues where it left off once hold returns high.
- R3: Serial input is sampled on rising serial-clock edges, MSB first. The first 8 bits are the opcode. Array commands then take 16 address bits, of which only the low ADDR_W bits are kept (for example, address 0xAB05 with ADDR_W=8 selects byte 0x05).
- R4: The opcodes are 0x01 status write, 0x02 array write, 0x03 array read, 0x04 latch clear, 0x05 status read and 0x06 latch set. Any other opcode is ignored: the output stays 1 and nothing changes until chip-select rises.
- R5: The status byte reads as {4'b0, bp[1:0], wel, 1'b0}. A status write copies only data bits 3:2 into bp and leaves wel unchanged.
- R6: An array data byte is stored only when wel=1 and the target is not protected. With the top two address bits t: bp=01 protects t=3, bp=10 protects t>=2, bp=11 protects everything and bp=00 protects nothing.
- R7: After each written byte, the low PAGE_W address bits increment and wrap, and the upper bits stay fixed. Writing continues until chip-select rises.
- R8: In a read, each rising serial-clock edge puts the next bit on the output, MSB first. An array read moves to the next byte after every 8 bits and wraps from the top of the array to 0. A status read repeats the same status byte.
- R9: The write-enable latch is cleared only by opcode 0x04. Array writes and status writes leave it set.
- R10: After reset the status byte is 0x00 and the output is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock |
| mosi | input | 1 | Serial data in |
| hold_n | input | 1 | Hold, active low |
| miso | output | 1 | Serial data out |

## Verification
The bench builds the block with ADDR_W=8 and PAGE_W=4, which gives 256 bytes in 16-byte pages. The array is small enough to fill completely and read back in one stream that wraps past its top. With these values every page boundary and all four protect boundaries (0x00, 0x7F/0x80, 0xBF/0xC0, 0xFF) are covered by a sweep over all protect codes. Expected bytes come from a shadow array in the bench that applies the latch, protect and page-wrap rules arithmetically.

// File: rtl/spi_eeprom_pkg.sv
package spi_eeprom_pkg;

    typedef enum logic [2:0] {
        ST_OPC,
        ST_ADR,
        ST_WR,
        ST_RD,
        ST_IDLE
    } seq_state_t;

    localparam logic [7:0] OP_WRSR = 8'h01;
    localparam logic [7:0] OP_WRITE = 8'h02;
    localparam logic [7:0] OP_READ = 8'h03;
    localparam logic [7:0] OP_WRDI = 8'h04;
    localparam logic [7:0] OP_RDSR = 8'h05;
    localparam logic [7:0] OP_WREN = 8'h06;

    typedef struct packed {
        logic [1:0] bp;
        logic       wel;
    } stat_t;

    function automatic logic region_locked(input logic [1:0] top, input logic [1:0] bp);
        case (bp)
            2'b01:   return top == 2'b11;
            2'b10:   return top[1];
            2'b11:   return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [7:0] stat_byte(input stat_t s);
        return {4'b0000, s.bp, s.wel, 1'b0};
    endfunction

endpackage

// File: rtl/spi_line_sync.sv
module spi_line_sync #(
    parameter int          W        = 4,
    parameter logic [W-1:0] RST_VAL = '0,
    parameter int          EDGE_IDX = 0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] level,
    output logic         rise
);
    logic [W-1:0] s1, s2;
    logic         prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1   <= RST_VAL;
            s2   <= RST_VAL;
            prev <= RST_VAL[EDGE_IDX];
        end else begin
            s1   <= din;
            s2   <= s1;
            prev <= s2[EDGE_IDX];
        end
    end

    assign level = s2;
    assign rise  = s2[EDGE_IDX] & ~prev;
endmodule

// File: rtl/spi_eeprom_mem.sv
module spi_eeprom_mem #(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          we,
    input  logic          re,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    wdata,
    output logic [7:0]    rdata
);
    localparam int DEPTH = 1 << AW;
    logic [7:0] arr [DEPTH];

    always_ff @(posedge clk) begin
        if (we) arr[addr] <= wdata;
        if (re) rdata <= arr[addr];
    end
endmodule

// File: rtl/spi_eeprom_fsm.sv
module spi_eeprom_fsm
    import spi_eeprom_pkg::*;
#(
    parameter int AW = 10,
    parameter int PW = 7
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cs_s,
    input  logic          hold_s,
    input  logic          si_s,
    input  logic          sck_rise,
    input  logic [7:0]    mem_rdata,
    output logic          mem_we,
    output logic          mem_re,
    output logic [AW-1:0] mem_addr,
    output logic [7:0]    mem_wdata,
    output logic [1:0]    bp_o,
    output logic          so
);
    localparam logic [AW-1:0] ONE = {{(AW-1){1'b0}}, 1'b1};
    localparam logic [PW-1:0] PONE = {{(PW-1){1'b0}}, 1'b1};

    seq_state_t    state;
    logic [3:0]    cnt;
    logic [7:0]    opc, sh, rdbuf;
    logic [15:0]   asr;
    logic [AW-1:0] addr;
    stat_t         stat;
    logic          ld_q;

    logic [7:0]  opc_nx, byte_nx;
    logic [15:0] asr_nx;
    assign opc_nx  = {opc[6:0], si_s};
    assign byte_nx = {sh[6:0], si_s};
    assign asr_nx  = {asr[14:0], si_s};
    assign bp_o    = stat.bp;

    always_ff @(posedge clk) begin
        mem_we <= 1'b0;
        mem_re <= 1'b0;
        ld_q   <= mem_re;
        if (ld_q) rdbuf <= mem_rdata;
        if (rst) begin
            state     <= ST_OPC;
            cnt       <= '0;
            opc       <= '0;
            sh        <= '0;
            asr       <= '0;
            addr      <= '0;
            stat      <= '0;
            so        <= 1'b1;
            rdbuf     <= '0;
            mem_addr  <= '0;
            mem_wdata <= '0;
            mem_we    <= 1'b0;
            mem_re    <= 1'b0;
            ld_q      <= 1'b0;
        end else if (hold_s) begin
            if (cs_s) begin
                cnt   <= '0;
                opc   <= '0;
                so    <= 1'b1;
                state <= ST_OPC;
            end else if (sck_rise) begin
                cnt <= cnt + 4'd1;
                unique case (state)
                    ST_OPC: begin
                        opc <= opc_nx;
                        if (cnt == 4'd7) begin
                            cnt <= '0;
                            case (opc_nx)
                                OP_WRSR: begin sh <= '0; state <= ST_WR; end
                                OP_WRITE, OP_READ: begin asr <= '0; state <= ST_ADR; end
                                OP_WRDI: begin stat.wel <= 1'b0; state <= ST_IDLE; end
                                OP_RDSR: begin rdbuf <= stat_byte(stat); state <= ST_RD; end
                                OP_WREN: begin stat.wel <= 1'b1; state <= ST_IDLE; end
                                default: state <= ST_IDLE;
                            endcase
                        end
                    end
                    ST_ADR: begin
                        asr <= asr_nx;
                        if (cnt == 4'd15) begin
                            cnt  <= '0;
                            addr <= asr_nx[AW-1:0];
                            if (opc[0]) begin
                                mem_re   <= 1'b1;
                                mem_addr <= asr_nx[AW-1:0];
                                state    <= ST_RD;
                            end else begin
                                sh    <= '0;
                                state <= ST_WR;
                            end
                        end
                    end
                    ST_WR: begin
                        sh <= byte_nx;
                        if (cnt == 4'd7) begin
                            cnt <= '0;
                            if (opc == OP_WRSR) begin
                                stat.bp <= byte_nx[3:2];
                                state   <= ST_IDLE;
                            end else begin
                                mem_we    <= stat.wel && !region_locked(addr[AW-1:AW-2], stat.bp);
                                mem_addr  <= addr;
                                mem_wdata <= byte_nx;
                                addr      <= {addr[AW-1:PW], addr[PW-1:0] + PONE};
                                sh        <= '0;
                            end
                        end
                    end
                    ST_RD: begin
                        so <= rdbuf[3'd7 - cnt[2:0]];
                        if (cnt == 4'd7) begin
                            cnt <= '0;
                            if (opc == OP_READ) begin
                                addr     <= addr + ONE;
                                mem_re   <= 1'b1;
                                mem_addr <= addr + ONE;
                            end
                        end
                    end
                    default: cnt <= '0;
                endcase
            end
        end
    end

    p_cs_release_r1: assert property (@(posedge clk) disable iff (rst)
        (hold_s && cs_s) |=> (so && state == ST_OPC && cnt == 4'd0));

    p_hold_freeze_r2: assert property (@(posedge clk) disable iff (rst)
        !hold_s |=> ($stable(state) && $stable(so) && $stable(stat) && $stable(cnt)));

    p_wel_clear_r9: assert property (@(posedge clk) disable iff (rst)
        $fell(stat.wel) |-> opc == OP_WRDI);

    p_page_fixed_r7: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WR && $past(state) == ST_WR) |-> addr[AW-1:PW] == $past(addr[AW-1:PW]));
endmodule

// File: rtl/spi_eeprom_slave.sv
module spi_eeprom_slave
    import spi_eeprom_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int PAGE_W = 7
) (
    input  logic clk,
    input  logic rst,
    input  logic cs_n,
    input  logic sck,
    input  logic mosi,
    input  logic hold_n,
    output logic miso
);
    logic [3:0]        lvl;
    logic              sck_rise;
    logic              mem_we, mem_re;
    logic [ADDR_W-1:0] mem_addr;
    logic [7:0]        mem_wdata, mem_rdata;
    logic [1:0]        bp;

    spi_line_sync #(.W(4), .RST_VAL(4'b1100), .EDGE_IDX(1)) u_sync (
        .clk(clk), .rst(rst),
        .din({hold_n, cs_n, sck, mosi}),
        .level(lvl), .rise(sck_rise)
    );

    spi_eeprom_fsm #(.AW(ADDR_W), .PW(PAGE_W)) u_fsm (
        .clk(clk), .rst(rst),
        .cs_s(lvl[2]), .hold_s(lvl[3]), .si_s(lvl[0]), .sck_rise(sck_rise),
        .mem_rdata(mem_rdata), .mem_we(mem_we), .mem_re(mem_re),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .bp_o(bp), .so(miso)
    );

    spi_eeprom_mem #(.AW(ADDR_W)) u_mem (
        .clk(clk), .we(mem_we), .re(mem_re), .addr(mem_addr),
        .wdata(mem_wdata), .rdata(mem_rdata)
    );

    p_write_unlocked_r6: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> !region_locked(mem_addr[ADDR_W-1:ADDR_W-2], bp));

    p_reset_idle_r10: assert property (@(posedge clk)
        $past(rst) |-> miso);
endmodule

// File: tb/spi_eeprom_slave_tb_top.sv
module spi_eeprom_slave_tb_top;
    localparam int AW = 8;
    localparam int PW = 4;
    localparam int HP = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cs_n = 1'b1, sck = 1'b0, mosi = 1'b0, hold_n = 1'b1;
    logic miso;

    int n_chk = 0, n_fail = 0, cyc = 0;
    logic [7:0] shadow [256];
    logic       wel_m = 1'b0;
    logic [1:0] bp_m = 2'b00;

    always #10 clk = ~clk;

    spi_eeprom_slave #(.ADDR_W(AW), .PAGE_W(PW)) dut_i (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .mosi(mosi),
        .hold_n(hold_n), .miso(miso)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic locked_m(input logic [7:0] a, input logic [1:0] bp);
        case (bp)
            2'b01:   return a[7:6] == 2'b11;
            2'b10:   return a[7];
            2'b11:   return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    task automatic sel();
        @(negedge clk) cs_n = 1'b0;
        repeat (HP) @(negedge clk);
    endtask

    task automatic desel();
        @(negedge clk) cs_n = 1'b1;
        repeat (HP) @(negedge clk);
    endtask

    task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
        for (int i = 7; i >= 0; i--) begin
            @(negedge clk) begin sck = 1'b0; mosi = tx[i]; end
            repeat (HP) @(negedge clk);
            sck = 1'b1;
            repeat (HP) @(negedge clk);
            rx[i] = miso;
        end
        @(negedge clk) sck = 1'b0;
    endtask

    task automatic cmd(input logic [7:0] op);
        logic [7:0] r;
        sel(); xfer(op, r); desel();
        if (op == 8'h06) wel_m = 1'b1;
        if (op == 8'h04) wel_m = 1'b0;
    endtask

    task automatic status_check(input string tag);
        logic [7:0] r;
        sel(); xfer(8'h05, r); xfer(8'h00, r); desel();
        check(tag, r, {4'b0, bp_m, wel_m, 1'b0});
    endtask

    task automatic status_write(input logic [7:0] v);
        logic [7:0] r;
        sel(); xfer(8'h01, r); xfer(v, r); desel();
        bp_m = v[3:2];
    endtask

    task automatic mem_write(input logic [15:0] a, input int n, input logic [7:0] seed);
        logic [7:0] r, ea, d;
        sel(); xfer(8'h02, r); xfer(a[15:8], r); xfer(a[7:0], r);
        ea = a[7:0];
        for (int k = 0; k < n; k++) begin
            d = seed + 8'(k * 13);
            xfer(d, r);
            if (wel_m && !locked_m(ea, bp_m)) shadow[ea] = d;
            ea = {ea[7:4], ea[3:0] + 4'd1};
        end
        desel();
    endtask

    task automatic mem_read(input logic [15:0] a, input int n, input string tag);
        logic [7:0] r, ea;
        sel(); xfer(8'h03, r); xfer(a[15:8], r); xfer(a[7:0], r);
        ea = a[7:0];
        for (int k = 0; k < n; k++) begin
            xfer(8'h00, r);
            check(tag, r, shadow[ea]);
            ea = ea + 8'd1;
        end
        desel();
    endtask

    initial begin
        int wd = 0;
        while (wd < 190000) begin @(posedge clk); wd++; end
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0d expected<%0d", wd, 190000);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [7:0] r, r2;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        check("R10 reset miso", miso, 1);
        status_check("R10 R5 reset status");

        cmd(8'h06);
        status_check("R4 R5 wel set");
        for (int p = 0; p < 16; p++) mem_write(16'(p * 16), 16, 8'(p * 29 + 3));
        status_check("R9 wel kept after writes");
        mem_read(16'h0000, 260, "R8 R3 full read with wrap");

        cmd(8'h04);
        status_check("R9 wel cleared by 04");
        mem_write(16'h0020, 2, 8'h55);
        mem_read(16'h0020, 2, "R6 no store when wel clear");

        cmd(8'h06);
        status_write(8'hFF);
        status_check("R5 status write keeps wel bp=11");
        for (int b = 0; b < 4; b++) begin
            status_write(8'(b << 2));
            status_check("R5 bp code");
            mem_write(16'h0000, 1, 8'(8'h11 + b));
            mem_write(16'h007F, 1, 8'(8'h22 + b));
            mem_write(16'h0080, 1, 8'(8'h33 + b));
            mem_write(16'h00BF, 1, 8'(8'h44 + b));
            mem_write(16'h00C0, 1, 8'(8'h55 + b));
            mem_write(16'h00FF, 1, 8'(8'h66 + b));
            mem_read(16'h0000, 1, "R6 prot 0x00");
            mem_read(16'h007F, 2, "R6 prot 0x7F/0x80");
            mem_read(16'h00BF, 2, "R6 prot 0xBF/0xC0");
            mem_read(16'h00FF, 1, "R6 prot 0xFF");
        end

        status_write(8'h00);
        mem_write(16'h003E, 4, 8'hA0);
        mem_read(16'h0030, 16, "R7 page wrap");
        mem_read(16'hAB05, 1, "R3 address mask");

        sel(); xfer(8'h07, r); xfer(8'h00, r); desel();
        check("R4 unknown opcode miso", r, 8'hFF);
        status_check("R4 unknown opcode no change");

        sel(); xfer(8'h05, r); xfer(8'h00, r); xfer(8'h00, r2); desel();
        check("R8 status repeat", r2, r);

        sel(); xfer(8'h05, r);
        @(negedge clk) hold_n = 1'b0;
        repeat (HP) @(negedge clk);
        for (int t = 0; t < 3; t++) begin
            sck = 1'b1; repeat (HP) @(negedge clk);
            sck = 1'b0; repeat (HP) @(negedge clk);
        end
        cs_n = 1'b1; repeat (HP) @(negedge clk);
        cs_n = 1'b0; repeat (HP) @(negedge clk);
        hold_n = 1'b1; repeat (HP) @(negedge clk);
        xfer(8'h00, r); desel();
        check("R2 hold ignores lines", r, {4'b0, bp_m, wel_m, 1'b0});

        sel(); xfer(8'h02, r); xfer(8'h00, r); desel();
        check("R1 miso high after abort", miso, 1);
        status_check("R1 fresh opcode after abort");
        sel(); xfer(8'h03, r); xfer(8'h00, r); xfer(8'h31, r); xfer(8'h00, r);
        @(negedge clk) cs_n = 1'b1;
        repeat (HP) @(negedge clk);
        check("R1 miso high after read end", miso, 1);
        mem_read(16'h0031, 1, "R1 state intact");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    always @(posedge clk) cyc <= cyc + 1;
endmodule